// File: doc/BRIEF.md
# Message Queue Deposit Engine

This block is the receive side of a memory-resident messaging scheme. A sender packs a message into eight 64-bit words and fires it at the engine, naming a queue rather than a memory address. Each queue is described by a control word holding a byte base address, a capacity counted in 64-byte slots, a tail index and a head index. The engine looks up that control word, decides whether a free slot exists, streams the eight words into the slot at the tail through a plain write port, and only then advances the tail.

Queues come into being when software writes a control word; nothing else sets one up, and any number of entries may serve user or system traffic. The hardware never reclaims space. Software drains a queue by moving its head index through a dedicated update port. A message that finds its queue full is refused without touching memory. When a message lands in a queue that held nothing, a one-cycle arrival pulse tells the processor to look. A read-only status port exposes the tail and head of any queue.

Top module: `mqd_engine`

## Requirements
- R1: After reset, `msg_ready` is 1, `mem_wr_en`, `irq_arrive` and `rej_full` are 0, and every queue reads tail 0 and head 0 with a capacity of zero.
- R2: A control-word write (`cw_we`) to queue q installs the given base and capacity and sets the tail and head of q to 0.
- R3: An accepted message produces exactly eight write beats. Beat i carries `msg_data[64*i+63:64*i]` to byte address base + tail*64 + i*8, in order i = 0 to 7. A beat's address and data stay unchanged until `mem_wr_accept` is seen.
- R4: The tail moves to (tail+1) mod capacity, which wraps to 0 at the capacity. This happens only after the eighth beat has been accepted.
- R5: A message is refused when the capacity is zero or when (tail+1) mod capacity equals the head. A refused message causes no write beat and leaves the tail unchanged. It produces a one-cycle `rej_full` pulse in the cycle after acceptance, with `evt_sel` naming the queue.
- R6: One cycle after the tail update, `irq_arrive` pulses for one cycle with `evt_sel` naming the queue, but only if tail equalled head when the message was accepted. `irq_arrive` and `rej_full` are never high together.
- R7: A head update (`hd_we`) writes `hd_val` into the head of the selected queue. The engine itself never changes a head, including when the head update falls in the same cycle as the engine's tail update.
- R8: `msg_ready` is low from the cycle after an accepted message until its tail update is done. This is at least nine cycles. Write beats begin only after an accepted message.
- R9: When a control-word write and the engine's tail update hit the same queue in the same cycle, the control-word write wins: the tail and head both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Engine able to take a message |
| msg_sel | input | QW | Target control word (queue index) |
| msg_data | input | 512 | Eight 64-bit words, word 0 in the low bits |
| cw_we | input | 1 | Create or redefine a queue |
| cw_sel | input | QW | Queue being defined |
| cw_base | input | 32 | Byte base address of the queue |
| cw_limit | input | 8 | Capacity in 64-byte slots |
| hd_we | input | 1 | Head update strobe |
| hd_sel | input | QW | Queue whose head moves |
| hd_val | input | 8 | New head index |
| mem_wr_en | output | 1 | Write beat valid |
| mem_wr_addr | output | 32 | Byte address of the beat |
| mem_wr_data | output | 64 | Beat data |
| mem_wr_accept | input | 1 | Memory takes the current beat |
| stat_sel | input | QW | Queue shown on the status outputs |
| stat_tail | output | 8 | Tail index of the shown queue |
| stat_head | output | 8 | Head index of the shown queue |
| irq_arrive | output | 1 | Message landed in an empty queue |
| rej_full | output | 1 | Message refused |
| evt_sel | output | QW | Queue named by the current pulse |

## Verification
Two pairs of functions can land in the same cycle. The first is the engine's tail update together with a software head update on the same queue. The second is the tail update together with a control-word write that redefines that queue. The bench holds the memory port permanently accepting so that the update cycle falls exactly nine cycles after acceptance, and it drives the competing strobe in that cycle. It then judges the outcome through the status port. In the head case the new tail and the new head must both survive. In the redefinition case tail and head must read 0, and the next message must land at the new base.

// File: rtl/mqd_pkg.sv
package mqd_pkg;

    localparam int MQD_AW      = 32;
    localparam int MQD_IW      = 8;
    localparam int MQD_WORDS   = 8;
    localparam int MQD_WW      = 64;
    localparam int MQD_MW      = MQD_WORDS * MQD_WW;
    localparam int MQD_BW      = $clog2(MQD_WORDS);
    localparam int MQD_WORD_SH = $clog2(MQD_WW / 8);
    localparam int MQD_SLOT_SH = $clog2(MQD_MW / 8);

    typedef struct packed {
        logic [MQD_AW-1:0] base;
        logic [MQD_IW-1:0] limit;
        logic [MQD_IW-1:0] tail;
        logic [MQD_IW-1:0] head;
    } mqd_cw_t;

    typedef enum logic [1:0] {
        MQD_IDLE,
        MQD_WRITE,
        MQD_COMMIT
    } mqd_state_e;

    function automatic logic [MQD_IW-1:0] next_idx(input logic [MQD_IW-1:0] idx,
                                                   input logic [MQD_IW-1:0] lim);
        logic [MQD_IW-1:0] inc;
        inc = idx + 1'b1;
        return (inc == lim) ? '0 : inc;
    endfunction

    function automatic logic [MQD_AW-1:0] slot_addr(input logic [MQD_AW-1:0] base,
                                                    input logic [MQD_IW-1:0] idx);
        return base + (MQD_AW'(idx) << MQD_SLOT_SH);
    endfunction

endpackage

// File: rtl/mqd_cw_table.sv
module mqd_cw_table
    import mqd_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cre_we,
    input  logic [QW-1:0]     cre_sel,
    input  logic [MQD_AW-1:0] cre_base,
    input  logic [MQD_IW-1:0] cre_limit,
    input  logic              hd_we,
    input  logic [QW-1:0]     hd_sel,
    input  logic [MQD_IW-1:0] hd_val,
    input  logic              cm_we,
    input  logic [QW-1:0]     cm_sel,
    input  logic [MQD_IW-1:0] cm_tail,
    input  logic [QW-1:0]     rd_sel_a,
    output mqd_cw_t           rd_a,
    input  logic [QW-1:0]     rd_sel_b,
    output mqd_cw_t           rd_b
);

    mqd_cw_t tbl [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_ent
        mqd_cw_t ent;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (cre_we && cre_sel == QW'(g)) begin
                // redefinition outranks any same-cycle tail or head update
                ent.base  <= cre_base;
                ent.limit <= cre_limit;
                ent.tail  <= '0;
                ent.head  <= '0;
            end else begin
                if (cm_we && cm_sel == QW'(g)) ent.tail <= cm_tail;
                if (hd_we && hd_sel == QW'(g)) ent.head <= hd_val;
            end
        end

        assign tbl[g] = ent;
    end

    assign rd_a = tbl[rd_sel_a];
    assign rd_b = tbl[rd_sel_b];

endmodule

// File: rtl/mqd_space_chk.sv
module mqd_space_chk
    import mqd_pkg::*;
(
    input  mqd_cw_t           cw,
    output logic              room,
    output logic              empty,
    output logic [MQD_IW-1:0] nxt
);

    always_comb begin
        nxt   = next_idx(cw.tail, cw.limit);
        empty = (cw.tail == cw.head);
        room  = (cw.limit != '0) && (nxt != cw.head);
    end

endmodule

// File: rtl/mqd_deposit.sv
module mqd_deposit
    import mqd_pkg::*;
#(
    parameter int QW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [QW-1:0]     msg_sel,
    input  logic [MQD_MW-1:0] msg_data,
    output logic              msg_ready,
    input  mqd_cw_t           cur_cw,
    input  logic              chk_room,
    input  logic              chk_empty,
    input  logic [MQD_IW-1:0] chk_nxt,
    output logic              mem_wr_en,
    output logic [MQD_AW-1:0] mem_wr_addr,
    output logic [MQD_WW-1:0] mem_wr_data,
    input  logic              mem_wr_accept,
    output logic              cm_we,
    output logic [QW-1:0]     cm_sel,
    output logic [MQD_IW-1:0] cm_tail,
    output logic              irq,
    output logic              rej,
    output logic [QW-1:0]     evt_sel
);

    localparam logic [MQD_BW-1:0] BEAT_LAST = MQD_BW'(MQD_WORDS - 1);

    mqd_state_e        st;
    logic [QW-1:0]     q_sel;
    logic [MQD_MW-1:0] q_data;
    logic [MQD_AW-1:0] q_slot;
    logic [MQD_IW-1:0] q_nxt;
    logic              q_empty;
    logic [MQD_BW-1:0] beat;
    logic              irq_q;
    logic              rej_q;
    logic [QW-1:0]     evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= MQD_IDLE;
            q_sel   <= '0;
            q_data  <= '0;
            q_slot  <= '0;
            q_nxt   <= '0;
            q_empty <= 1'b0;
            beat    <= '0;
            irq_q   <= 1'b0;
            rej_q   <= 1'b0;
            evt_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            rej_q <= 1'b0;
            unique case (st)
                MQD_IDLE: begin
                    if (msg_valid) begin
                        if (chk_room) begin
                            q_sel   <= msg_sel;
                            q_data  <= msg_data;
                            q_slot  <= slot_addr(cur_cw.base, cur_cw.tail);
                            q_nxt   <= chk_nxt;
                            q_empty <= chk_empty;
                            beat    <= '0;
                            st      <= MQD_WRITE;
                        end else begin
                            rej_q <= 1'b1;
                            evt_q <= msg_sel;
                        end
                    end
                end
                MQD_WRITE: begin
                    if (mem_wr_accept) begin
                        if (beat == BEAT_LAST) st <= MQD_COMMIT;
                        else                   beat <= beat + 1'b1;
                    end
                end
                MQD_COMMIT: begin
                    irq_q <= q_empty;
                    evt_q <= q_sel;
                    st    <= MQD_IDLE;
                end
                default: st <= MQD_IDLE;
            endcase
        end
    end

    always_comb begin
        msg_ready   = (st == MQD_IDLE);
        mem_wr_en   = (st == MQD_WRITE);
        mem_wr_addr = q_slot + (MQD_AW'(beat) << MQD_WORD_SH);
        mem_wr_data = q_data[beat*MQD_WW +: MQD_WW];
        cm_we       = (st == MQD_COMMIT);
        cm_sel      = q_sel;
        cm_tail     = q_nxt;
        irq         = irq_q;
        rej         = rej_q;
        evt_sel     = evt_q;
    end

endmodule

// File: rtl/mqd_engine.sv
module mqd_engine
    import mqd_pkg::*;
#(
    parameter  int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [QW-1:0]     msg_sel,
    input  logic [MQD_MW-1:0] msg_data,
    input  logic              cw_we,
    input  logic [QW-1:0]     cw_sel,
    input  logic [MQD_AW-1:0] cw_base,
    input  logic [MQD_IW-1:0] cw_limit,
    input  logic              hd_we,
    input  logic [QW-1:0]     hd_sel,
    input  logic [MQD_IW-1:0] hd_val,
    output logic              mem_wr_en,
    output logic [MQD_AW-1:0] mem_wr_addr,
    output logic [MQD_WW-1:0] mem_wr_data,
    input  logic              mem_wr_accept,
    input  logic [QW-1:0]     stat_sel,
    output logic [MQD_IW-1:0] stat_tail,
    output logic [MQD_IW-1:0] stat_head,
    output logic              irq_arrive,
    output logic              rej_full,
    output logic [QW-1:0]     evt_sel
);

    mqd_cw_t           cw_msg;
    mqd_cw_t           cw_stat;
    logic              room;
    logic              empty;
    logic [MQD_IW-1:0] nxt;
    logic              cm_we;
    logic [QW-1:0]     cm_sel;
    logic [MQD_IW-1:0] cm_tail;

    mqd_cw_table #(.NQ(NQ), .QW(QW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cre_we   (cw_we),
        .cre_sel  (cw_sel),
        .cre_base (cw_base),
        .cre_limit(cw_limit),
        .hd_we    (hd_we),
        .hd_sel   (hd_sel),
        .hd_val   (hd_val),
        .cm_we    (cm_we),
        .cm_sel   (cm_sel),
        .cm_tail  (cm_tail),
        .rd_sel_a (msg_sel),
        .rd_a     (cw_msg),
        .rd_sel_b (stat_sel),
        .rd_b     (cw_stat)
    );

    mqd_space_chk u_space (
        .cw   (cw_msg),
        .room (room),
        .empty(empty),
        .nxt  (nxt)
    );

    mqd_deposit #(.QW(QW)) u_dep (
        .clk          (clk),
        .rst          (rst),
        .msg_valid    (msg_valid),
        .msg_sel      (msg_sel),
        .msg_data     (msg_data),
        .msg_ready    (msg_ready),
        .cur_cw       (cw_msg),
        .chk_room     (room),
        .chk_empty    (empty),
        .chk_nxt      (nxt),
        .mem_wr_en    (mem_wr_en),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_accept(mem_wr_accept),
        .cm_we        (cm_we),
        .cm_sel       (cm_sel),
        .cm_tail      (cm_tail),
        .irq          (irq_arrive),
        .rej          (rej_full),
        .evt_sel      (evt_sel)
    );

    assign stat_tail = cw_stat.tail;
    assign stat_head = cw_stat.head;

endmodule

// File: rtl/mqd_engine_chk.sv
module mqd_engine_chk
    import mqd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              mem_wr_en,
    input logic [MQD_AW-1:0] mem_wr_addr,
    input logic [MQD_WW-1:0] mem_wr_data,
    input logic              mem_wr_accept,
    input logic              irq_arrive,
    input logic              rej_full
);

    logic [MQD_BW-1:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst)                             acc_cnt <= '0;
        else if (mem_wr_en && mem_wr_accept) acc_cnt <= acc_cnt + 1'b1;
    end

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en && !mem_wr_accept |=> mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R3

    AST_BEAT_STRIDE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en && mem_wr_accept && acc_cnt != MQD_BW'(MQD_WORDS - 1)
        |=> mem_wr_en && mem_wr_addr == $past(mem_wr_addr) + MQD_AW'(MQD_WW / 8)); // R3

    AST_WHOLE_MESSAGE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_en) |-> acc_cnt == '0); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !msg_ready); // R8

    AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_en) |-> $past(msg_valid && msg_ready)); // R8

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        rej_full |-> !mem_wr_en); // R5

    AST_ARRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_arrive |-> msg_ready && !mem_wr_en); // R6

    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_arrive && rej_full)); // R6

endmodule

bind mqd_engine mqd_engine_chk u_mqd_chk (
    .clk          (clk),
    .rst          (rst),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .mem_wr_en    (mem_wr_en),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_accept(mem_wr_accept),
    .irq_arrive   (irq_arrive),
    .rej_full     (rej_full)
);

// File: tb/test_mqd_engine.sv
`timescale 1ns/1ps
module test_mqd_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [1:0]   msg_sel = '0;
    logic [511:0] msg_data = '0;
    logic         cw_we = 1'b0;
    logic [1:0]   cw_sel = '0;
    logic [31:0]  cw_base = '0;
    logic [7:0]   cw_limit = '0;
    logic         hd_we = 1'b0;
    logic [1:0]   hd_sel = '0;
    logic [7:0]   hd_val = '0;
    logic         mem_wr_en;
    logic [31:0]  mem_wr_addr;
    logic [63:0]  mem_wr_data;
    logic         mem_wr_accept = 1'b1;
    logic [1:0]   stat_sel = '0;
    logic [7:0]   stat_tail;
    logic [7:0]   stat_head;
    logic         irq_arrive;
    logic         rej_full;
    logic [1:0]   evt_sel;

    always #2.5 clk = ~clk;

    mqd_engine #(.NQ(4)) i_mqd_engine (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_sel(msg_sel), .msg_data(msg_data),
        .cw_we(cw_we), .cw_sel(cw_sel), .cw_base(cw_base), .cw_limit(cw_limit),
        .hd_we(hd_we), .hd_sel(hd_sel), .hd_val(hd_val),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_accept(mem_wr_accept),
        .stat_sel(stat_sel), .stat_tail(stat_tail), .stat_head(stat_head),
        .irq_arrive(irq_arrive), .rej_full(rej_full), .evt_sel(evt_sel)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit stall_en = 0;
    int cyc = 0;

    // memory-side model: log of accepted beats
    int          wcount = 0;
    logic [31:0] wa [8];
    logic [63:0] wd [8];

    always @(posedge clk) begin
        if (!rst && mem_wr_en && mem_wr_accept) begin
            wa[wcount & 7] = mem_wr_addr;
            wd[wcount & 7] = mem_wr_data;
            wcount++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        mem_wr_accept <= !stall_en || (cyc % 3 != 1);
    end

    // reference model of each queue
    int m_base [4];
    int m_lim  [4];
    int m_tl   [4];
    int m_hd   [4];

    function automatic logic [63:0] word(input int seed, input int i);
        return {32'(seed) ^ 32'hC3A5_0000, 32'(i) * 32'h0101_0101 + 32'(seed)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_stat(input int q);
        stat_sel = 2'(q);
        #0.5;
        chk(stat_tail == 8'(m_tl[q]), "R4 tail via status", 64'(stat_tail), 64'(m_tl[q]));
        chk(stat_head == 8'(m_hd[q]), "R7 head via status", 64'(stat_head), 64'(m_hd[q]));
    endtask

    task automatic create(input int q, input int base, input int lim);
        @(negedge clk);
        cw_we = 1; cw_sel = 2'(q); cw_base = 32'(base); cw_limit = 8'(lim);
        @(negedge clk);
        cw_we = 0;
        m_base[q] = base; m_lim[q] = lim; m_tl[q] = 0; m_hd[q] = 0;
        stat_sel = 2'(q);
        #0.5;
        chk(stat_tail == 0 && stat_head == 0, "R2 create clears indices",
            {stat_tail, stat_head}, 64'd0);
    endtask

    task automatic move_head(input int q, input int v);
        @(negedge clk);
        hd_we = 1; hd_sel = 2'(q); hd_val = 8'(v);
        @(negedge clk);
        hd_we = 0;
        m_hd[q] = v;
        check_stat(q);
    endtask

    task automatic check_beats(input int q, input int start, input int seed);
        chk(wcount - start == 8, "R3 beat count", 64'(wcount - start), 64'd8);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] ea;
            ea = 32'(m_base[q] + m_tl[q] * 64 + i * 8);
            chk(wa[(start + i) & 7] == ea, "R3 beat address", 64'(wa[(start + i) & 7]), 64'(ea));
            chk(wd[(start + i) & 7] == word(seed, i), "R3 beat data", wd[(start + i) & 7], word(seed, i));
        end
    endtask

    task automatic send(input int q, input int seed);
        int nx;
        bit exp_ok;
        bit exp_empty;
        int start;
        int busy;
        nx        = (m_tl[q] + 1 == m_lim[q]) ? 0 : m_tl[q] + 1;
        exp_ok    = (m_lim[q] != 0) && (nx != m_hd[q]);
        exp_empty = (m_tl[q] == m_hd[q]);
        @(negedge clk);
        msg_valid = 1; msg_sel = 2'(q);
        for (int i = 0; i < 8; i++) msg_data[i*64 +: 64] = word(seed, i);
        start = wcount;
        @(posedge clk);
        @(negedge clk);
        msg_valid = 0;
        if (msg_ready) begin
            chk(!exp_ok, "R5 refusal decision", 64'd0, 64'(exp_ok));
            chk(rej_full == 1'b1, "R5 refusal pulse", 64'(rej_full), 64'd1);
            chk(evt_sel == 2'(q), "R5 refusal queue", 64'(evt_sel), 64'(q));
            chk(wcount == start, "R5 no beat on refusal", 64'(wcount - start), 64'd0);
            @(negedge clk);
            chk(rej_full == 1'b0, "R5 refusal lasts one cycle", 64'(rej_full), 64'd0);
        end else begin
            busy = 1;
            while (!msg_ready) begin
                @(negedge clk);
                if (!msg_ready) busy++;
            end
            chk(exp_ok, "R5 acceptance decision", 64'd1, 64'(exp_ok));
            chk(busy >= 9, "R8 busy span", 64'(busy), 64'd9);
            chk(irq_arrive == exp_empty, "R6 arrival pulse", 64'(irq_arrive), 64'(exp_empty));
            if (exp_empty)
                chk(evt_sel == 2'(q), "R6 arrival queue", 64'(evt_sel), 64'(q));
            chk(rej_full == 1'b0, "R6 no refusal with deposit", 64'(rej_full), 64'd0);
            check_beats(q, start, seed);
            m_tl[q] = nx;
        end
        check_stat(q);
    endtask

    // mode 1: head update in the tail-update cycle; mode 2: redefinition in that cycle
    task automatic send_clash(input int q, input int seed, input int mode,
                              input int hv, input int nbase, input int nlim);
        int nx;
        int start;
        nx = (m_tl[q] + 1 == m_lim[q]) ? 0 : m_tl[q] + 1;
        @(negedge clk);
        msg_valid = 1; msg_sel = 2'(q);
        for (int i = 0; i < 8; i++) msg_data[i*64 +: 64] = word(seed, i);
        start = wcount;
        @(posedge clk);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 1) msg_valid = 0;
        end
        if (mode == 1) begin
            hd_we = 1; hd_sel = 2'(q); hd_val = 8'(hv);
        end else begin
            cw_we = 1; cw_sel = 2'(q); cw_base = 32'(nbase); cw_limit = 8'(nlim);
        end
        @(posedge clk);
        @(negedge clk);
        hd_we = 0; cw_we = 0;
        chk(msg_ready == 1'b1, "R8 ready after tail update", 64'(msg_ready), 64'd1);
        chk(irq_arrive == 1'b0, "R6 no arrival on non-empty queue", 64'(irq_arrive), 64'd0);
        check_beats(q, start, seed);
        if (mode == 1) begin
            m_tl[q] = nx; m_hd[q] = hv;
            check_stat(q); // R7 both updates survive
        end else begin
            m_base[q] = nbase; m_lim[q] = nlim; m_tl[q] = 0; m_hd[q] = 0;
            stat_sel = 2'(q);
            #0.5;
            chk(stat_tail == 0, "R9 redefinition wins tail", 64'(stat_tail), 64'd0);
            chk(stat_head == 0, "R9 redefinition wins head", 64'(stat_head), 64'd0);
        end
    endtask

    initial begin
        for (int q = 0; q < 4; q++) begin
            m_base[q] = 0; m_lim[q] = 0; m_tl[q] = 0; m_hd[q] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(msg_ready == 1'b1, "R1 ready after reset", 64'(msg_ready), 64'd1);
        chk(mem_wr_en == 1'b0, "R1 no beat after reset", 64'(mem_wr_en), 64'd0);
        chk(irq_arrive == 1'b0 && rej_full == 1'b0, "R1 pulses low after reset",
            {irq_arrive, rej_full}, 64'd0);
        for (int q = 0; q < 4; q++) check_stat(q);

        // unconfigured queue: capacity zero refuses
        send(0, 11);

        // sweep: every capacity 1..4, fill past full, drain, refill across the wrap
        stall_en = 1;
        for (int q = 0; q < 4; q++) create(q, 32'h1000 * (q + 1), q + 1);
        for (int q = 0; q < 4; q++) begin
            for (int n = 0; n <= m_lim[q]; n++) send(q, 100 * q + n);
            move_head(q, m_tl[q]);
            for (int n = 0; n < m_lim[q]; n++) send(q, 100 * q + 50 + n);
        end

        // same-cycle collisions with a free-flowing memory port
        stall_en = 0;
        repeat (3) @(negedge clk);
        create(3, 32'h8000, 4);
        send(3, 700);
        send_clash(3, 701, 1, 1, 0, 0);
        send(3, 702);

        create(1, 32'h9000, 4);
        send(1, 800);
        send_clash(1, 801, 2, 0, 32'hA000, 2);
        send(1, 802);
        send(1, 803);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=idle");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule